// File: doc/BRIEF.md
# SYSREF Request Input Conditioner

This block turns an asynchronous external request line into a clean internal request for a clock-distribution datapath. The line is first brought into the local clock domain, then optionally held by a first-edge latch, gated by a clear control, and finally delayed by a programmable number of clock cycles. The delay stands in for a coarse alignment delay, so a board-level request can be placed relative to the local clock.

A function select decides what the request is used for. In synchronisation use, the rising edge of the delayed request produces a one-cycle pulse that resets downstream dividers, and the reference outputs are muted while the request is high. In request use, the internal request only drives the reference generator. A software trigger can stand in for the pin. A repeater flag marks the case where the clear control must not block the request path.

Top module: `sysref_req_cond`

## Requirements
- R1: After reset all outputs are 0. With a delay of 0, a level change on `req_pin` shows on `int_req` after exactly 3 rising clock edges: two synchroniser stages and one output register.
- R2: A delay value d in 0..63 on `delay_step` adds exactly d cycles to the latency of R1, and a request pulse keeps its width in cycles.
- R3: With `latch_en`=1, the first rising edge of the request holds `int_req` high. Later activity on the pin has no effect until `clr` is asserted, which releases the hold.
- R4: With `latch_en`=0, `int_req` follows the delayed request level, with no holding.
- R5: While `clr`=1 and `rpt_mode`=0, `int_req` is 0 from the next clock edge, even with `sw_trig`=1. Any request already inside the delay line is discarded.
- R6: With `rpt_mode`=1, `clr` does not force `int_req` low.
- R7: With `sw_trig`=1, the request is treated as constantly high and `req_pin` is ignored.
- R8: With `req_mode`=0 (synchronise), `sync_pulse` is high for exactly one cycle, in the same cycle that `int_req` rises. With `req_mode`=1 (reference request), `sync_pulse` stays 0.
- R9: After reset, no `sync_pulse` is produced until `clr` has been asserted at least once.
- R10: With `req_mode`=0 and `mute_dis`=0, `sysref_mute` is high exactly in the cycles where `int_req` is high. In all other settings it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pin | input | 1 | Asynchronous external request line |
| latch_en | input | 1 | 1: hold the request after its first rising edge |
| clr | input | 1 | Clears the latch and the delay line and forces the request low (unless repeater) |
| sw_trig | input | 1 | Software request, acts as a constant high request |
| req_mode | input | 1 | 0: synchronise function, 1: reference request function |
| rpt_mode | input | 1 | 1: repeater operation, `clr` does not gate the request |
| mute_dis | input | 1 | 1: no output muting during synchronisation |
| delay_step | input | 6 | Extra delay in clock cycles, 0..63 |
| int_req | output | 1 | Conditioned internal request |
| sync_pulse | output | 1 | One-cycle divider reset pulse |
| sysref_mute | output | 1 | Mute flag for the reference outputs |

## Verification
Every delay value from 0 to 63 is swept with pin pulses of varying width. Rise latency separates synchroniser depth from delay-line tap selection, and high-time separates a correct tap from a stuck or shortened one. Pulses in synchronise mode, before and after the first clear, separate the arming rule from plain edge detection, and the mute count distinguishes the mute-disable setting from the function select. Latched pulses, a software trigger with a toggling pin, a clear in and out of repeater operation, and a clear issued while a request is still inside the delay line each expose one of the gating paths.

// File: rtl/src_pkg.sv
package src_pkg;

    typedef enum logic {
        FN_SYNC = 1'b0,
        FN_SREQ = 1'b1
    } req_fn_e;

    typedef struct packed {
        logic clr;
        logic rpt;
        logic latch_en;
        logic sw_trig;
    } req_ctl_t;

    typedef struct packed {
        logic req;
        logic pulse;
        logic mute;
    } req_out_t;

    function automatic logic ctl_forces_low(input req_ctl_t c);
        return c.clr && !c.rpt;
    endfunction

endpackage

// File: rtl/src_sync.sv
module src_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/src_latch.sv
module src_latch (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic latch_en,
    input  logic clr,
    output logic lvl
);
    logic raw_d;
    logic held;
    logic rise;

    assign rise = raw && !raw_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_d <= 1'b0;
            held  <= 1'b0;
        end else begin
            raw_d <= raw;
            if (clr)                 held <= 1'b0;
            else if (latch_en && rise) held <= 1'b1;
        end
    end

    assign lvl = latch_en ? (held || rise) : raw;

    // R3: once held, only clear releases the latch
    a_r3_latch_hold: assert property (@(posedge clk) disable iff (rst)
        (held && !clr) |=> held);
endmodule

// File: rtl/src_delay.sv
module src_delay #(
    parameter int STEP_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              d,
    input  logic [STEP_W-1:0] step,
    output logic              q
);
    localparam int DEPTH = (1 << STEP_W) - 1;

    logic [DEPTH-1:0] line;
    logic [DEPTH:0]   taps;

    always_ff @(posedge clk) begin
        if (rst || flush) line <= '0;
        else              line <= {line[DEPTH-2:0], d};
    end

    assign taps = {line, d};
    assign q    = taps[step];

    // R5: a flush leaves nothing in flight
    a_r5_flush_empty: assert property (@(posedge clk) disable iff (rst)
        flush |=> (line == '0));
endmodule

// File: rtl/sysref_req_cond.sv
module sysref_req_cond
    import src_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STEP_W      = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_pin,
    input  logic              latch_en,
    input  logic              clr,
    input  logic              sw_trig,
    input  logic              req_mode,
    input  logic              rpt_mode,
    input  logic              mute_dis,
    input  logic [STEP_W-1:0] delay_step,
    output logic              int_req,
    output logic              sync_pulse,
    output logic              sysref_mute
);
    req_ctl_t ctl;
    req_out_t out_q;
    req_out_t out_n;
    req_fn_e  fn;
    logic     pin_s;
    logic     raw;
    logic     lvl;
    logic     force_low;
    logic     gated;
    logic     tap;
    logic     armed;

    assign ctl       = '{clr: clr, rpt: rpt_mode, latch_en: latch_en, sw_trig: sw_trig};
    assign fn        = req_fn_e'(req_mode);
    assign force_low = ctl_forces_low(ctl);

    src_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_pin),
        .q   (pin_s)
    );

    assign raw = ctl.sw_trig || pin_s;

    src_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .raw      (raw),
        .latch_en (ctl.latch_en),
        .clr      (ctl.clr),
        .lvl      (lvl)
    );

    assign gated = force_low ? 1'b0 : lvl;

    src_delay #(.STEP_W(STEP_W)) u_delay (
        .clk   (clk),
        .rst   (rst),
        .flush (force_low),
        .d     (gated),
        .step  (delay_step),
        .q     (tap)
    );

    always_comb begin
        out_n.req   = force_low ? 1'b0 : tap;
        out_n.pulse = (fn == FN_SYNC) && armed && out_n.req && !out_q.req;
        out_n.mute  = (fn == FN_SYNC) && !mute_dis && out_n.req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            armed <= 1'b0;
        end else begin
            out_q <= out_n;
            if (ctl.clr) armed <= 1'b1;
        end
    end

    assign int_req     = out_q.req;
    assign sync_pulse  = out_q.pulse;
    assign sysref_mute = out_q.mute;

    // R8: divider reset pulse lasts one cycle
    a_r8_pulse_single: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |=> !sync_pulse);
    // R8: pulse marks the rising edge of the request
    a_r8_pulse_on_rise: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |-> (int_req && !$past(int_req)));
    // R9: no pulse before the first clear
    a_r9_armed_first: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |-> armed);
    // R5: clear outside repeater forces the request low
    a_r5_clr_low: assert property (@(posedge clk) disable iff (rst)
        (clr && !rpt_mode) |=> !int_req);
    // R10: mute only while a request is active
    a_r10_mute_req: assert property (@(posedge clk) disable iff (rst)
        sysref_mute |-> int_req);
endmodule

// File: tb/sysref_req_cond_tb_top.sv
`timescale 1ns/1ps
module sysref_req_cond_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       req_pin, latch_en, clr, sw_trig, req_mode, rpt_mode, mute_dis;
    logic [5:0] delay_step;
    logic       int_req, sync_pulse, sysref_mute;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    sysref_req_cond dut_i (
        .clk(clk), .rst(rst), .req_pin(req_pin), .latch_en(latch_en), .clr(clr),
        .sw_trig(sw_trig), .req_mode(req_mode), .rpt_mode(rpt_mode), .mute_dis(mute_dis),
        .delay_step(delay_step), .int_req(int_req), .sync_pulse(sync_pulse),
        .sysref_mute(sysref_mute)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Pin pulse of width w cycles; returns first cycle int_req is high,
    // number of high cycles, pulse count, cycle of pulse and mute cycles.
    task automatic measure(input int w, input int d, output int rise_k, output int hi,
                           output int pulses, output int pulse_k, output int mutes);
        rise_k = -1; hi = 0; pulses = 0; pulse_k = -1; mutes = 0;
        req_pin = 1'b1;
        for (int k = 1; k <= w + d + 8; k++) begin
            @(negedge clk);
            if (int_req) begin
                hi++;
                if (rise_k < 0) rise_k = k;
            end
            if (sync_pulse) begin
                pulses++;
                if (pulse_k < 0) pulse_k = k;
            end
            if (sysref_mute) mutes++;
            if (k == w) req_pin = 1'b0;
        end
    endtask

    task automatic pulse_clr;
        clr = 1'b1;
        wait_n(1);
        clr = 1'b0;
        wait_n(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int rk, hi, np, pk, nm, bad;
        rst = 1'b1; req_pin = 0; latch_en = 0; clr = 0; sw_trig = 0;
        req_mode = 0; rpt_mode = 0; mute_dis = 0; delay_step = 0;
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        chk("R1 reset int_req", int_req, 0);
        chk("R1 reset sync_pulse", sync_pulse, 0);
        chk("R1 reset mute", sysref_mute, 0);

        // R9: unarmed sync mode, request passes but no pulse
        measure(4, 0, rk, hi, np, pk, nm);
        chk("R1 latency d=0", rk, 3);
        chk("R9 no pulse before clear", np, 0);
        chk("R10 mute follows request", nm, 4);

        // R8: armed
        pulse_clr();
        measure(4, 0, rk, hi, np, pk, nm);
        chk("R8 one pulse", np, 1);
        chk("R8 pulse with rise", pk, rk);
        chk("R10 mute cycles", nm, hi);

        // R10: mute disabled
        mute_dis = 1'b1;
        delay_step = 6'd2;
        measure(3, 2, rk, hi, np, pk, nm);
        chk("R10 mute disabled", nm, 0);
        chk("R8 pulse with delay", np, 1);
        mute_dis = 1'b0;

        // R8/R10: request function
        req_mode = 1'b1;
        measure(3, 2, rk, hi, np, pk, nm);
        chk("R8 no pulse in request function", np, 0);
        chk("R10 no mute in request function", nm, 0);

        // R2/R4: delay sweep
        for (int d = 0; d < 64; d++) begin
            delay_step = 6'(d);
            measure(1 + d % 5, d, rk, hi, np, pk, nm);
            chk($sformatf("R2 latency d=%0d", d), rk, 3 + d);
            chk($sformatf("R4 width d=%0d", d), hi, 1 + d % 5);
        end

        // R3: latch
        delay_step = 6'd0;
        latch_en = 1'b1;
        measure(2, 0, rk, hi, np, pk, nm);
        chk("R3 latch rise", rk, 3);
        chk("R3 latch holds", hi, 2 + 0 + 6);
        measure(2, 0, rk, hi, np, pk, nm);
        chk("R3 second pulse no effect", hi, 10);
        clr = 1'b1;
        wait_n(1);
        chk("R5 clear drops latched request", int_req, 0);
        clr = 1'b0;
        wait_n(10);
        chk("R3 latch released", int_req, 0);
        latch_en = 1'b0;

        // R7: software trigger
        sw_trig = 1'b1;
        wait_n(5);
        bad = 0;
        for (int k = 0; k < 12; k++) begin
            req_pin = k[0];
            wait_n(1);
            if (!int_req) bad++;
        end
        req_pin = 1'b0;
        chk("R7 pin ignored under trigger", bad, 0);
        clr = 1'b1;
        wait_n(1);
        chk("R5 clear overrides trigger", int_req, 0);
        rpt_mode = 1'b1;
        wait_n(2);
        chk("R6 repeater ignores clear", int_req, 1);
        clr = 1'b0; rpt_mode = 1'b0; sw_trig = 1'b0;
        wait_n(10);
        chk("R7 trigger released", int_req, 0);

        // R5: clear flushes a request inside the delay line
        delay_step = 6'd10;
        req_pin = 1'b1;
        wait_n(2);
        req_pin = 1'b0;
        wait_n(4);
        clr = 1'b1;
        wait_n(1);
        clr = 1'b0;
        hi = 0;
        for (int k = 0; k < 25; k++) begin
            wait_n(1);
            if (int_req) hi++;
        end
        chk("R5 delay line flushed", hi, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule